// File: doc/BRIEF.md
# IDE Channel I/O Address Decoder

This block sits beside the configuration registers of a two-channel IDE host controller. It reads their current contents and works out where each channel lives in I/O space. For each channel it produces the command-block base, the control-block base, an enable, and the interrupt-routing mode. It also produces the two halves of the shared bus-master register window. It does not store configuration itself. The register file drives its inputs directly.

Each channel picks its addresses on its own. In compatibility mode a channel uses fixed addresses. In native mode it uses the base registers that software programmed. An incoming I/O request is compared against every window. Hit strobes show which channel's command block, control port or bus-master half the address falls in.

All outputs are registered. Every output therefore reflects the inputs that were present at the previous rising clock edge.

Top module: `ide_io_decode`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge.
- R2: When `prog_if[0]` is 0, channel 0 reports command base 0x01F0 and control base 0x03F6.
- R3: When `prog_if[2]` is 0, channel 1 reports command base 0x0170 and control base 0x0376.
- R4: When a channel's native bit is 1 (`prog_if[0]` for channel 0, `prog_if[2]` for channel 1), its command and control bases equal `cmd_bar[c]` and `ctl_bar[c]` with bit 0 forced to 0.
- R5: `chan_en[0]` equals `io_en & gen_ctl[1]`, and `chan_en[1]` equals `io_en & gen_ctl[2]`.
- R6: `cmd_hit[c]` is 1 when `io_req` is high, channel c is enabled, and `(io_addr - cmd_base) mod 65536` is less than 8. An address 8 above the base does not hit.
- R7: `ctl_hit[c]` is 1 only when `io_req` is high, channel c is enabled, and `io_addr` equals the control base exactly.
- R8: A disabled channel raises neither `cmd_hit` nor `ctl_hit`, even when the address matches its window.
- R9: `bm_base[0]` is `bm_bar` with bits 3:0 cleared, and `bm_base[1]` is that value plus 8. `bm_hit[0]` is raised when `io_req` and `io_en` are high, `io_addr[15:4]` equals `bm_bar[15:4]` and `io_addr[3]` is 0. `bm_hit[1]` is raised under the same conditions except that `io_addr[3]` is 1. Neither `bm_hit` bit depends on `gen_ctl`.
- R10: `irq_native[c]` equals the channel's native bit; 1 means native interrupt routing and 0 means the fixed IRQ14/IRQ15 routing.
- R11: Every output reflects the inputs sampled at the previous rising edge (one cycle of latency), so a configuration change takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_en | input | 1 | I/O space enable from the command register |
| prog_if | input | 8 | Programming-interface byte (bit 0 ch0 native, bit 2 ch1 native) |
| gen_ctl | input | 8 | General control byte (bit 1 ch0 on, bit 2 ch1 on) |
| cmd_bar | input | 2x16 | Native command-block base register per channel |
| ctl_bar | input | 2x16 | Native control-block base register per channel |
| bm_bar | input | 16 | Bus-master base register |
| io_req | input | 1 | An I/O access is presented on io_addr |
| io_addr | input | 16 | I/O address of the access |
| chan_en | output | 2 | Channel decode enable |
| cmd_base | output | 2x16 | Active command-block base per channel |
| ctl_base | output | 2x16 | Active control-block base per channel |
| bm_base | output | 2x16 | Bus-master register window base per channel |
| irq_native | output | 2 | 1 = native interrupt routing, 0 = legacy routing |
| cmd_hit | output | 2 | Address falls in the channel's command block |
| ctl_hit | output | 2 | Address is the channel's control port |
| bm_hit | output | 2 | Address falls in the channel's bus-master half |

## Verification
A wrong mode selection shows on `cmd_base`, `ctl_base` and `irq_native` one cycle after the configuration changes. A wrong enable gate or range compare shows as a missing or extra hit one cycle after the access is presented. The reference model predicts every output for every cycle, so a defect is caught in the first cycle it produces a difference. The stimulus aims most addresses near the active windows: at the window edges, just past them, and across the 16-bit wrap. This exercises the off-by-one and bit-0 masking cases.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int NCH = 2;

  // fixed compatibility addresses per channel
  function automatic logic [15:0] legacy_cmd(input int ch);
    return (ch == 0) ? 16'h01F0 : 16'h0170;
  endfunction

  function automatic logic [15:0] legacy_ctl(input int ch);
    return (ch == 0) ? 16'h03F6 : 16'h0376;
  endfunction

  // bit of the programming-interface byte selecting native mode
  function automatic int native_bit(input int ch);
    return ch * 2;
  endfunction

  // bit of the general control byte turning the channel on
  function automatic int on_bit(input int ch);
    return ch + 1;
  endfunction
endpackage

// File: rtl/ide_chan_map.sv
module ide_chan_map #(
  parameter int AW = 16,
  parameter int CMD_SPAN = 8,
  parameter logic [AW-1:0] LEG_CMD = '0,
  parameter logic [AW-1:0] LEG_CTL = '0
) (
  input  logic          native,
  input  logic          io_en,
  input  logic          chan_on,
  input  logic [AW-1:0] cmd_bar,
  input  logic [AW-1:0] ctl_bar,
  input  logic          io_req,
  input  logic [AW-1:0] io_addr,
  output logic          en,
  output logic [AW-1:0] cmd_base,
  output logic [AW-1:0] ctl_base,
  output logic          cmd_hit,
  output logic          ctl_hit
);
  logic [AW-1:0] cmd_off;

  always_comb begin
    en       = io_en & chan_on;
    cmd_base = native ? {cmd_bar[AW-1:1], 1'b0} : LEG_CMD;
    ctl_base = native ? {ctl_bar[AW-1:1], 1'b0} : LEG_CTL;
    cmd_off  = io_addr - cmd_base;
    cmd_hit  = en & io_req & (32'(cmd_off) < CMD_SPAN);
    ctl_hit  = en & io_req & (io_addr == ctl_base);
  end

  logic unused_bits;
  assign unused_bits = cmd_bar[0] ^ ctl_bar[0];
endmodule

// File: rtl/ide_bm_window.sv
module ide_bm_window #(
  parameter int AW = 16,
  parameter int HALF = 8
) (
  input  logic                  io_en,
  input  logic [AW-1:0]         bm_bar,
  input  logic                  io_req,
  input  logic [AW-1:0]         io_addr,
  output logic [1:0][AW-1:0]    bm_base,
  output logic [1:0]            bm_hit
);
  localparam int LW = $clog2(2 * HALF);

  logic in_win;

  always_comb begin
    bm_base[0] = {bm_bar[AW-1:LW], {LW{1'b0}}};
    bm_base[1] = bm_base[0] + AW'(HALF);
    in_win     = io_en & io_req & (io_addr[AW-1:LW] == bm_bar[AW-1:LW]);
    bm_hit[0]  = in_win & ~io_addr[LW-1];
    bm_hit[1]  = in_win &  io_addr[LW-1];
  end

  logic unused_bits;
  assign unused_bits = ^{bm_bar[LW-1:0], io_addr[LW-2:0]};
endmodule

// File: rtl/ide_io_decode.sv
module ide_io_decode
  import ide_dec_pkg::*;
#(
  parameter int AW = 16,
  parameter int CMD_SPAN = 8,
  parameter int BM_HALF = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    io_en,
  input  logic [7:0]              prog_if,
  input  logic [7:0]              gen_ctl,
  input  logic [NCH-1:0][AW-1:0]  cmd_bar,
  input  logic [NCH-1:0][AW-1:0]  ctl_bar,
  input  logic [AW-1:0]           bm_bar,
  input  logic                    io_req,
  input  logic [AW-1:0]           io_addr,
  output logic [NCH-1:0]          chan_en,
  output logic [NCH-1:0][AW-1:0]  cmd_base,
  output logic [NCH-1:0][AW-1:0]  ctl_base,
  output logic [NCH-1:0][AW-1:0]  bm_base,
  output logic [NCH-1:0]          irq_native,
  output logic [NCH-1:0]          cmd_hit,
  output logic [NCH-1:0]          ctl_hit,
  output logic [NCH-1:0]          bm_hit
);
  localparam int BM_LW = $clog2(2 * BM_HALF);

  logic [NCH-1:0]          en_d, cmd_hit_d, ctl_hit_d, native_d;
  logic [NCH-1:0][AW-1:0]  cmd_base_d, ctl_base_d, bm_base_d;
  logic [1:0]              bm_hit_d;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign native_d[c] = prog_if[native_bit(c)];

    ide_chan_map #(
      .AW(AW), .CMD_SPAN(CMD_SPAN),
      .LEG_CMD(AW'(legacy_cmd(c))), .LEG_CTL(AW'(legacy_ctl(c)))
    ) u_map (
      .native  (native_d[c]),
      .io_en   (io_en),
      .chan_on (gen_ctl[on_bit(c)]),
      .cmd_bar (cmd_bar[c]),
      .ctl_bar (ctl_bar[c]),
      .io_req  (io_req),
      .io_addr (io_addr),
      .en      (en_d[c]),
      .cmd_base(cmd_base_d[c]),
      .ctl_base(ctl_base_d[c]),
      .cmd_hit (cmd_hit_d[c]),
      .ctl_hit (ctl_hit_d[c])
    );

    // R8: a disabled channel never reports a hit
    p_off_no_hit_r8: assert property (@(posedge clk) disable iff (rst)
      !chan_en[c] |-> (!cmd_hit[c] && !ctl_hit[c]));

    // R10: routing mode follows the native bit from the previous edge
    p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (irq_native[c] == $past(prog_if[native_bit(c)])));
  end

  ide_bm_window #(.AW(AW), .HALF(BM_HALF)) u_bm (
    .io_en  (io_en),
    .bm_bar (bm_bar),
    .io_req (io_req),
    .io_addr(io_addr),
    .bm_base(bm_base_d),
    .bm_hit (bm_hit_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en    <= '0;
      cmd_base   <= '0;
      ctl_base   <= '0;
      bm_base    <= '0;
      irq_native <= '0;
      cmd_hit    <= '0;
      ctl_hit    <= '0;
      bm_hit     <= '0;
    end else begin
      chan_en    <= en_d;
      cmd_base   <= cmd_base_d;
      ctl_base   <= ctl_base_d;
      bm_base    <= bm_base_d;
      irq_native <= native_d;
      cmd_hit    <= cmd_hit_d;
      ctl_hit    <= ctl_hit_d;
      bm_hit     <= bm_hit_d;
    end
  end

  logic unused_cfg;
  assign unused_cfg = ^{prog_if[7:3], prog_if[1], gen_ctl[7:3], gen_ctl[0]};

  // R2: compatibility addresses for channel 0
  p_legacy_pri_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(prog_if[0])) |->
      (cmd_base[0] == AW'(16'h01F0) && ctl_base[0] == AW'(16'h03F6)));

  // R9: the lower bus-master half only answers offsets with bit 3 clear
  p_bm_half_r9: assert property (@(posedge clk) disable iff (rst)
    bm_hit[0] |-> !$past(io_addr[BM_LW-1]));

  // R11: no hit without a request and I/O space enabled one cycle earlier
  p_hit_needs_req_r11: assert property (@(posedge clk) disable iff (rst)
    (|{cmd_hit, ctl_hit, bm_hit}) |-> ($past(io_req) && $past(io_en)));
endmodule

// File: tb/ide_io_decode_test.sv
module ide_io_decode_test;
  logic clk = 0;
  always #5 clk = ~clk;

  logic             rst;
  logic             io_en;
  logic [7:0]       prog_if, gen_ctl;
  logic [1:0][15:0] cmd_bar, ctl_bar;
  logic [15:0]      bm_bar;
  logic             io_req;
  logic [15:0]      io_addr;
  logic [1:0]       chan_en, irq_native, cmd_hit, ctl_hit, bm_hit;
  logic [1:0][15:0] cmd_base, ctl_base, bm_base;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  ide_io_decode uut (
    .clk, .rst, .io_en, .prog_if, .gen_ctl, .cmd_bar, .ctl_bar, .bm_bar,
    .io_req, .io_addr, .chan_en, .cmd_base, .ctl_base, .bm_base,
    .irq_native, .cmd_hit, .ctl_hit, .bm_hit
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected outputs from the inputs applied before the last edge
  task automatic compare(input bit was_rst);
    for (int c = 0; c < 2; c++) begin
      int nat, en, cb, kb, mb, ch, kh, mh, off;
      if (was_rst) begin
        chk("R1 chan_en", chan_en[c], 0);
        chk("R1 cmd_base", cmd_base[c], 0);
        chk("R1 ctl_base", ctl_base[c], 0);
        chk("R1 bm_base", bm_base[c], 0);
        chk("R1 irq", irq_native[c], 0);
        chk("R1 hits", {cmd_hit[c], ctl_hit[c], bm_hit[c]}, 0);
        continue;
      end
      nat = prog_if[c * 2];
      en  = io_en && gen_ctl[c + 1];
      if (nat) begin
        cb = cmd_bar[c] & 16'hFFFE;
        kb = ctl_bar[c] & 16'hFFFE;
      end else begin
        cb = (c == 0) ? 16'h01F0 : 16'h0170;
        kb = (c == 0) ? 16'h03F6 : 16'h0376;
      end
      off = (io_addr - cb) & 16'hFFFF;
      ch  = en && io_req && off < 8;
      kh  = en && io_req && io_addr == kb;
      mb  = (bm_bar & 16'hFFF0) + c * 8;
      mh  = io_en && io_req && ((io_addr & 16'hFFF0) == (bm_bar & 16'hFFF0))
            && (((io_addr >> 3) & 1) == c);
      chk("R5 chan_en", chan_en[c], en);
      chk(nat ? "R4 cmd_base" : (c == 0 ? "R2 cmd_base" : "R3 cmd_base"), cmd_base[c], cb);
      chk(nat ? "R4 ctl_base" : (c == 0 ? "R2 ctl_base" : "R3 ctl_base"), ctl_base[c], kb);
      chk("R10 irq_native", irq_native[c], nat);
      chk(en ? "R6 cmd_hit" : "R8 cmd_hit", cmd_hit[c], ch);
      chk(en ? "R7 ctl_hit" : "R8 ctl_hit", ctl_hit[c], kh);
      chk("R9 bm_base", bm_base[c], mb);
      chk("R9 bm_hit", bm_hit[c], mh);
    end
  endtask

  // drive inputs, wait one edge, compare (R11: one-cycle latency)
  task automatic step;
    bit r = rst;
    @(posedge clk);
    #1;
    compare(r);
  endtask

  function automatic logic [15:0] pick_addr();
    int k = $urandom_range(0, 6);
    int c = $urandom_range(0, 1);
    logic [15:0] b;
    case (k)
      0: return ((c == 0) ? 16'h01F0 : 16'h0170) + 16'($urandom_range(0, 9)) - 16'd1;
      1: return ((c == 0) ? 16'h03F6 : 16'h0376) + 16'($urandom_range(0, 2)) - 16'd1;
      2: begin b = cmd_bar[c] & 16'hFFFE; return b + 16'($urandom_range(0, 9)) - 16'd1; end
      3: begin b = ctl_bar[c] & 16'hFFFE; return b + 16'($urandom_range(0, 2)) - 16'd1; end
      4: begin b = bm_bar & 16'hFFF0; return b + 16'($urandom_range(0, 17)) - 16'd1; end
      default: return 16'($urandom());
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1; io_en = 1; prog_if = 8'h8A; gen_ctl = 8'h06;
    cmd_bar[0] = 16'h01F1; ctl_bar[0] = 16'h03F5;
    cmd_bar[1] = 16'h0171; ctl_bar[1] = 16'h0375;
    bm_bar = 16'hF001; io_req = 1; io_addr = 16'h01F0;
    #1;
    step; step;                              // R1
    rst = 0;
    io_addr = 16'h01F0; step;                // R2 legacy command hit
    io_addr = 16'h01F7; step;                // R6 last address
    io_addr = 16'h01F8; step;                // R6 one past
    io_addr = 16'h03F6; step;                // R7
    io_addr = 16'h03F7; step;                // R7 miss
    io_addr = 16'h0376; step;                // R3
    io_addr = 16'hF007; step;                // R9 lower half
    io_addr = 16'hF008; step;                // R9 upper half
    gen_ctl = 8'h00; step;                   // R9 independent of gen_ctl
    io_addr = 16'h01F3; step;                // R8 disabled
    gen_ctl = 8'h04; step;                   // R5 only channel 1
    gen_ctl = 8'h06; io_en = 0; step;        // R5 io off
    io_en = 1; io_req = 0; step;             // no request
    io_req = 1; prog_if = 8'h8F;
    cmd_bar[0] = 16'hFFFD; ctl_bar[0] = 16'h1235;
    io_addr = 16'h0002; step;                // R4 native, R6 wrap
    io_addr = 16'h1234; step;                // R4 bit 0 cleared control
    io_addr = 16'hFFFC; step;
    for (int i = 0; i < 3000; i++) begin
      if (i % 40 == 0) begin
        prog_if = 8'($urandom()); gen_ctl = 8'($urandom());
        io_en = ($urandom_range(0, 7) != 0);
        cmd_bar[0] = 16'($urandom()); cmd_bar[1] = 16'($urandom());
        ctl_bar[0] = 16'($urandom()); ctl_bar[1] = 16'($urandom());
        bm_bar = 16'($urandom());
      end
      rst = (i == 1500);
      io_req = ($urandom_range(0, 5) != 0);
      io_addr = pick_addr();
      step;
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule